// File: doc/BRIEF.md
# Presence-Vector Snoop Filter

This block sits beside the coherent interconnect of a small multi-node system and remembers, for a fixed set of cache lines, which nodes may currently hold a copy. Every snooped request is looked up by line address. The block answers in the same cycle with a forward mask, so that only nodes whose presence bit is set are probed. Nodes whose bit is clear never see the snoop. Reads add the requester to the line's presence vector. Writes and exclusive requests leave the requester as the only holder. Eviction notices from nodes remove them from the vector.

The table is fully associative. A request for an untracked line takes a free entry if one exists. When every entry is in use, the block picks a victim: the entry tracked by the fewest nodes, and among equals the one idle for longest. It then raises a back-invalidate carrying the victim's address and presence mask, stops accepting requests, and installs the new line only after the back-invalidate is acknowledged.

Top module: `snoop_filter`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1, `binv_valid` is 0, and any first lookup returns an empty forward mask.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. `req_kind` 2'b00 means read, and 2'b11 is also treated as read. On a tracked line, a read returns in that same cycle `fwd_valid`=1 and `fwd_mask` = the line's presence bits with the requester's own bit (bit `req_node`) removed. The read then adds the requester's bit.
- R3: A write or exclusive request (`req_kind` 2'b01) to a tracked line forwards to every other present node in the same way as a read. Afterwards only the requester's bit remains set.
- R4: An eviction notice (`req_kind` 2'b10) gives `fwd_valid`=0 and clears the sender's bit. When the vector becomes empty the entry becomes invalid, and a later request to that line is a miss. A notice for an untracked line changes nothing.
- R5: A read or write that misses while a free entry exists installs the line with only the requester's bit, gives `fwd_valid`=1 with `fwd_mask`=0, and raises no back-invalidate. Free entries are taken lowest index first.
- R6: A miss with every entry valid selects as victim the entry with the fewest presence bits set.
- R7: Among victims tied on bit count, the one with the largest age wins. A remaining tie goes to the lowest index.
- R8: Each entry has an 8-bit age. A read, a write or an install resets it to 0. Every other table-changing request adds 1, and so does an eviction notice that hits the entry. The age saturates at 255.
- R9: On a full miss, `binv_valid` rises in the next cycle with the victim's address and presence mask. `req_ready` stays 0 and both values stay stable until `binv_ack`. On acknowledge, the pending line replaces the victim with only the requester's bit, and `req_ready` returns the next cycle. `binv_ack` at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Snooped request present |
| req_ready | output | 1 | Filter can accept a request |
| req_kind | input | 2 | 00 read, 01 write/exclusive, 10 eviction notice, 11 read |
| req_node | input | 2 | Requesting node index |
| req_addr | input | 32 | Cache line address |
| fwd_valid | output | 1 | Forward mask valid for the accepted request |
| fwd_mask | output | 4 | Nodes to be probed |
| binv_valid | output | 1 | Back-invalidate request |
| binv_addr | output | 32 | Address of the evicted line |
| binv_mask | output | 4 | Nodes holding the evicted line |
| binv_ack | input | 1 | Back-invalidate acknowledge |

## Verification
The hardest condition to reach is a full table in which the minimum-count entries differ only by age, and in particular one where saturation, rather than wrap-around, decides the victim. The stimulus fills all sixteen entries. It then trims presence vectors with eviction notices to create ties, and drives a long run of accesses to one line so that one idle entry pins at 255, while another that would be older under wrap-around sits just below it. A behavioural model of the table, victim choice and back-invalidate state is compared against the ports every cycle. This includes cycles where the acknowledge is held off and a request is left waiting.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam logic [1:0] KIND_READ = 2'b00;
  localparam logic [1:0] KIND_EXCL = 2'b01;
  localparam logic [1:0] KIND_DROP = 2'b10;

  typedef enum logic [2:0] {
    OP_HOLD, OP_AGE, OP_SHARE, OP_OWN, OP_DROP, OP_FILL
  } ent_op_e;

  typedef enum logic {ST_IDLE, ST_WAIT} sf_state_e;
endpackage

// File: rtl/sf_entry.sv
module sf_entry
  import sf_pkg::*;
#(
  parameter int NODES = 4,
  parameter int AW    = 32,
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ent_op_e          op,
  input  logic [NODES-1:0] node_bit,
  input  logic [AW-1:0]    fill_addr,
  output logic             valid,
  output logic [AW-1:0]    addr,
  output logic [NODES-1:0] vec,
  output logic [AGE_W-1:0] age
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [NODES-1:0] vec_less;
  assign vec_less = vec & ~node_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      vec   <= '0;
      age   <= '0;
    end else begin
      case (op)
        OP_AGE: if (valid && age != AGE_MAX) age <= age + 1'b1;
        OP_SHARE: begin vec <= vec | node_bit; age <= '0; end
        OP_OWN:   begin vec <= node_bit;       age <= '0; end
        OP_DROP: begin
          vec <= vec_less;
          if (age != AGE_MAX) age <= age + 1'b1;
          if (vec_less == '0) valid <= 1'b0;
        end
        OP_FILL: begin
          valid <= 1'b1;
          addr  <= fill_addr;
          vec   <= node_bit;
          age   <= '0;
        end
        default: ;
      endcase
    end
  end

  // R4
  live_has_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> vec != '0);

  // R8
  age_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && age == AGE_MAX && op == OP_AGE) |=> age == AGE_MAX);
endmodule

// File: rtl/sf_lookup.sv
module sf_lookup #(
  parameter int ENTRIES = 16,
  parameter int AW      = 32,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ENTRIES-1:0]         valid_v,
  input  logic [ENTRIES-1:0][AW-1:0] addr_a,
  input  logic [AW-1:0]              key,
  output logic                       hit,
  output logic [IW-1:0]              hit_idx,
  output logic                       has_free,
  output logic [IW-1:0]              free_idx
);
  logic [ENTRIES-1:0] match;

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    has_free = 1'b0;
    free_idx = '0;
    match    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      match[i] = valid_v[i] && (addr_a[i] == key);
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
      if (!valid_v[i]) begin
        has_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/sf_victim.sv
module sf_victim #(
  parameter int ENTRIES = 16,
  parameter int NODES   = 4,
  parameter int AGE_W   = 8,
  localparam int IW     = $clog2(ENTRIES),
  localparam int CW     = $clog2(NODES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_en,
  input  logic [ENTRIES-1:0][NODES-1:0] vecs,
  input  logic [ENTRIES-1:0][AGE_W-1:0] ages,
  output logic [IW-1:0]                 vic_idx
);
  logic [CW-1:0] cnt [ENTRIES];

  function automatic logic ranks_before(input logic [CW-1:0] ca, input logic [AGE_W-1:0] aa,
                                        input logic [CW-1:0] cb, input logic [AGE_W-1:0] ab);
    return (ca < cb) || ((ca == cb) && (aa > ab));
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cnt
    assign cnt[g] = CW'($countones(vecs[g]));

    // R6
    fewest_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_en |-> cnt[vic_idx] <= cnt[g]);

    // R7
    oldest_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_en && cnt[vic_idx] == cnt[g]) |-> ages[vic_idx] >= ages[g]);
  end

  always_comb begin
    vic_idx = '0;
    for (int i = 1; i < ENTRIES; i++) begin
      if (ranks_before(cnt[i], ages[i], cnt[vic_idx], ages[vic_idx])) vic_idx = IW'(i);
    end
  end
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
  import sf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int NODES   = 4,
  parameter int AW      = 32,
  parameter int AGE_W   = 8,
  localparam int IW     = $clog2(ENTRIES),
  localparam int NW     = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [NW-1:0]    req_node,
  input  logic [AW-1:0]    req_addr,
  output logic             fwd_valid,
  output logic [NODES-1:0] fwd_mask,
  output logic             binv_valid,
  output logic [AW-1:0]    binv_addr,
  output logic [NODES-1:0] binv_mask,
  input  logic             binv_ack
);
  logic [ENTRIES-1:0]            e_valid;
  logic [ENTRIES-1:0][AW-1:0]    e_addr;
  logic [ENTRIES-1:0][NODES-1:0] e_vec;
  logic [ENTRIES-1:0][AGE_W-1:0] e_age;
  ent_op_e                       e_op [ENTRIES];

  sf_state_e        state;
  logic [IW-1:0]    vic_q;
  logic [AW-1:0]    pend_addr;
  logic [NODES-1:0] pend_bit;
  logic [AW-1:0]    binv_addr_q;
  logic [NODES-1:0] binv_mask_q;

  // named events
  logic             acc, is_excl, is_drop, hit, has_free;
  logic             free_miss, full_miss, ack_take, tick;
  logic [IW-1:0]    hit_idx, free_idx, vic_idx, tgt_idx;
  logic [NODES-1:0] node_bit, upd_bit;
  logic [AW-1:0]    upd_addr;
  ent_op_e          tgt_op;

  assign node_bit  = NODES'(1) << req_node;
  assign req_ready = (state == ST_IDLE);
  assign acc       = req_valid && req_ready;
  assign is_excl   = (req_kind == KIND_EXCL);
  assign is_drop   = (req_kind == KIND_DROP);
  assign free_miss = acc && !hit && !is_drop && has_free;
  assign full_miss = acc && !hit && !is_drop && !has_free;
  assign ack_take  = (state == ST_WAIT) && binv_ack;
  assign tick      = ack_take || (acc && (hit || free_miss));
  assign tgt_idx   = ack_take ? vic_q : (hit ? hit_idx : free_idx);
  assign upd_bit   = ack_take ? pend_bit : node_bit;
  assign upd_addr  = ack_take ? pend_addr : req_addr;

  always_comb begin
    if (ack_take || free_miss) tgt_op = OP_FILL;
    else if (is_drop)          tgt_op = OP_DROP;
    else if (is_excl)          tgt_op = OP_OWN;
    else                       tgt_op = OP_SHARE;
  end

  sf_lookup #(.ENTRIES(ENTRIES), .AW(AW)) u_lookup (
    .clk(clk), .rst_n(rst_n), .valid_v(e_valid), .addr_a(e_addr), .key(req_addr),
    .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx)
  );

  sf_victim #(.ENTRIES(ENTRIES), .NODES(NODES), .AGE_W(AGE_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .sel_en(full_miss), .vecs(e_vec), .ages(e_age),
    .vic_idx(vic_idx)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_comb begin
      e_op[g] = OP_HOLD;
      if (tick) e_op[g] = (tgt_idx == IW'(g)) ? tgt_op : OP_AGE;
    end

    sf_entry #(.NODES(NODES), .AW(AW), .AGE_W(AGE_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .op(e_op[g]), .node_bit(upd_bit), .fill_addr(upd_addr),
      .valid(e_valid[g]), .addr(e_addr[g]), .vec(e_vec[g]), .age(e_age[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      vic_q       <= '0;
      pend_addr   <= '0;
      pend_bit    <= '0;
      binv_addr_q <= '0;
      binv_mask_q <= '0;
    end else if (full_miss) begin
      state       <= ST_WAIT;
      vic_q       <= vic_idx;
      pend_addr   <= req_addr;
      pend_bit    <= node_bit;
      binv_addr_q <= e_addr[vic_idx];
      binv_mask_q <= e_vec[vic_idx];
    end else if (ack_take) begin
      state <= ST_IDLE;
    end
  end

  assign fwd_valid  = acc && !is_drop;
  assign fwd_mask   = (fwd_valid && hit) ? (e_vec[hit_idx] & ~node_bit) : '0;
  assign binv_valid = (state == ST_WAIT);
  assign binv_addr  = binv_addr_q;
  assign binv_mask  = binv_mask_q;

  // R9
  binv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_valid && !binv_ack) |=> (binv_valid && $stable(binv_addr) && $stable(binv_mask)));

  // R9
  binv_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    binv_valid |-> !req_ready);

  // R9
  binv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (binv_valid && binv_ack) |=> (req_ready && !binv_valid));

  // R6
  binv_mask_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    binv_valid |-> binv_mask != '0);
endmodule

// File: tb/tb_snoop_filter.sv
module tb_snoop_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'b00;
  logic [1:0]  req_node = 2'd0;
  logic [31:0] req_addr = '0;
  logic        fwd_valid;
  logic [3:0]  fwd_mask;
  logic        binv_valid;
  logic [31:0] binv_addr;
  logic [3:0]  binv_mask;
  logic        binv_ack = 1'b0;

  always #4 clk = ~clk;

  snoop_filter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_node(req_node), .req_addr(req_addr),
    .fwd_valid(fwd_valid), .fwd_mask(fwd_mask), .binv_valid(binv_valid),
    .binv_addr(binv_addr), .binv_mask(binv_mask), .binv_ack(binv_ack)
  );

  int checks = 0;
  int fails  = 0;

  // reference model
  bit          m_v   [16];
  logic [31:0] m_a   [16];
  logic [3:0]  m_vec [16];
  int          m_age [16];
  bit          m_wait;
  int          m_vic;
  logic [31:0] m_baddr, m_paddr;
  logic [3:0]  m_bmask, m_pbit;

  // last observed values for directed checks
  logic [3:0]  got_fmask;
  logic [31:0] got_baddr;
  logic [3:0]  got_bmask;
  string       tag = "R1";

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_a[i] = '0; m_vec[i] = '0; m_age[i] = 0;
    end
    m_wait = 0; m_vic = 0;
  endtask

  function automatic int find_hit(logic [31:0] a);
    for (int i = 0; i < 16; i++) if (m_v[i] && m_a[i] == a) return i;
    return -1;
  endfunction

  task automatic age_all_but(int t);
    for (int j = 0; j < 16; j++)
      if (j != t && m_v[j] && m_age[j] < 255) m_age[j]++;
  endtask

  function automatic int pick_victim();
    int best = 0;
    for (int i = 1; i < 16; i++) begin
      int ci = $countones(m_vec[i]);
      int cb = $countones(m_vec[best]);
      if (ci < cb || (ci == cb && m_age[i] > m_age[best])) best = i;
    end
    return best;
  endfunction

  // one clock: compare before the edge, then advance the model
  task automatic cycle();
    logic [3:0] bitv;
    int h;
    bit acc;
    logic [3:0] e_fm;
    bit e_fv;
    #2;
    bitv = 4'b0001 << req_node;
    acc  = req_valid && !m_wait;
    h    = find_hit(req_addr);
    e_fv = acc && req_kind != 2'b10;
    e_fm = (e_fv && h >= 0) ? (m_vec[h] & ~bitv) : 4'b0;
    check(tag, "req_ready", {31'b0, req_ready}, {31'b0, !m_wait});
    check(tag, "fwd_valid", {31'b0, fwd_valid}, {31'b0, e_fv});
    check(tag, "fwd_mask", {28'b0, fwd_mask}, {28'b0, e_fm});
    check(tag, "binv_valid", {31'b0, binv_valid}, {31'b0, m_wait});
    if (m_wait) begin
      check(tag, "binv_addr", binv_addr, m_baddr);
      check(tag, "binv_mask", {28'b0, binv_mask}, {28'b0, m_bmask});
      got_baddr = binv_addr;
      got_bmask = binv_mask;
    end
    if (e_fv) got_fmask = fwd_mask;
    @(posedge clk);
    if (m_wait) begin
      if (binv_ack) begin
        m_v[m_vic] = 1; m_a[m_vic] = m_paddr; m_vec[m_vic] = m_pbit; m_age[m_vic] = 0;
        age_all_but(m_vic);
        m_wait = 0;
      end
    end else if (acc) begin
      if (h >= 0) begin
        age_all_but(h);
        if (req_kind == 2'b10) begin
          m_vec[h] = m_vec[h] & ~bitv;
          if (m_age[h] < 255) m_age[h]++;
          if (m_vec[h] == 0) m_v[h] = 0;
        end else if (req_kind == 2'b01) begin
          m_vec[h] = bitv; m_age[h] = 0;
        end else begin
          m_vec[h] = m_vec[h] | bitv; m_age[h] = 0;
        end
      end else if (req_kind != 2'b10) begin
        int f = -1;
        for (int i = 15; i >= 0; i--) if (!m_v[i]) f = i;
        if (f >= 0) begin
          m_v[f] = 1; m_a[f] = req_addr; m_vec[f] = bitv; m_age[f] = 0;
          age_all_but(f);
        end else begin
          m_vic = pick_victim();
          m_baddr = m_a[m_vic]; m_bmask = m_vec[m_vic];
          m_paddr = req_addr; m_pbit = bitv;
          m_wait = 1;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; binv_ack = 1'b0;
    @(negedge clk); @(negedge clk);
    model_clear();
    rst_n = 1'b1;
  endtask

  // issue one request; on a full miss, hold it for 'stall' cycles then acknowledge
  task automatic issue(string rq, logic [1:0] k, logic [1:0] n, logic [31:0] a, int stall = 2);
    tag = rq;
    req_valid = 1'b1; req_kind = k; req_node = n; req_addr = a;
    cycle();
    if (m_wait) begin
      for (int s = 0; s < stall; s++) cycle();   // request still offered, must be ignored
      req_valid = 1'b0;
      binv_ack = 1'b1;
      cycle();
      binv_ack = 1'b0;
    end
    req_valid = 1'b0;
  endtask

  task automatic idle(string rq, int n);
    tag = rq;
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();
    // R1: reset state
    idle("R1", 1);
    check("R1", "ready_after_reset", {31'b0, req_ready}, 32'd1);
    check("R1", "binv_after_reset", {31'b0, binv_valid}, 32'd0);
    issue("R1", 2'b00, 2'd0, 32'h100);
    check("R1", "first_lookup_mask", {28'b0, got_fmask}, 32'd0);

    // R2: read sharing and forward masks
    issue("R2", 2'b00, 2'd1, 32'h100);
    check("R2", "fwd_n1", {28'b0, got_fmask}, 32'h1);
    issue("R2", 2'b11, 2'd2, 32'h100);
    check("R2", "fwd_n2_alt_read", {28'b0, got_fmask}, 32'h3);

    // R3: exclusive leaves only requester
    issue("R3", 2'b01, 2'd3, 32'h100);
    check("R3", "fwd_excl", {28'b0, got_fmask}, 32'h7);
    issue("R3", 2'b00, 2'd0, 32'h100);
    check("R3", "fwd_after_excl", {28'b0, got_fmask}, 32'h8);

    // R4: eviction notices
    issue("R4", 2'b10, 2'd0, 32'h100);
    issue("R4", 2'b10, 2'd1, 32'h200);        // untracked: no change
    issue("R4", 2'b10, 2'd3, 32'h100);        // vector empties -> invalid
    issue("R4", 2'b00, 2'd1, 32'h100);
    check("R4", "miss_after_empty", {28'b0, got_fmask}, 32'h0);

    // R9: acknowledge with nothing pending is ignored
    tag = "R9"; binv_ack = 1'b1; cycle(); binv_ack = 1'b0;
    issue("R9", 2'b00, 2'd2, 32'h100);
    check("R9", "stray_ack_no_effect", {28'b0, got_fmask}, 32'h2);

    // R5/R6: fill table, one single-owner line
    do_reset();
    for (int i = 0; i < 16; i++) begin
      if (i == 7) issue("R5", 2'b00, 2'd2, 32'h1000 + i);
      else begin
        issue("R5", 2'b00, 2'd0, 32'h1000 + i);
        issue("R5", 2'b00, 2'd1, 32'h1000 + i);
      end
    end
    check("R5", "no_binv_while_free", {31'b0, binv_valid}, 32'd0);
    issue("R6", 2'b00, 2'd3, 32'h2000, 4);
    check("R6", "victim_addr", got_baddr, 32'h1007);
    check("R6", "victim_mask", {28'b0, got_bmask}, 32'h4);
    issue("R9", 2'b00, 2'd0, 32'h2000);
    check("R9", "installed_after_ack", {28'b0, got_fmask}, 32'h8);

    // R7: ties broken by age
    issue("R7", 2'b10, 2'd1, 32'h1002);
    issue("R7", 2'b10, 2'd1, 32'h1009);
    issue("R7", 2'b00, 2'd3, 32'h3000, 0);
    check("R7", "tie_oldest_first", got_baddr, 32'h1002);
    issue("R7", 2'b01, 2'd2, 32'h3001, 1);
    check("R7", "tie_second", got_baddr, 32'h1009);
    check("R7", "tie_second_mask", {28'b0, got_bmask}, 32'h1);

    // R8: saturation decides the victim
    do_reset();
    for (int i = 0; i < 16; i++) issue("R8", 2'b00, 2'd0, 32'h5000 + i);
    for (int i = 1; i < 15; i++) issue("R8", 2'b00, 2'd0, 32'h5000 + i);
    for (int i = 0; i < 240; i++) issue("R8", 2'b00, 2'd0, 32'h500F);
    issue("R8", 2'b00, 2'd1, 32'h6000, 1);
    check("R8", "saturated_victim", got_baddr, 32'h5000);
    issue("R8", 2'b00, 2'd1, 32'h6001, 1);
    check("R8", "next_victim", got_baddr, 32'h5001);

    idle("R1", 2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule